// File: doc/BRIEF.md
# Channeliser Lane Packet Checker

This block sits behind the word decoder of one serial output lane of a fine channeliser. It receives 16-bit words through a valid/data interface and finds the fixed-length packets in that stream. Each packet is one header word, one identifier word, one counter word, a run of sample words and a closing checksum word. The block hunts for the header value, which cannot appear as a legal sample, and then tracks packet positions. It checks the XOR checksum and checks that the four nested counters (bank, channel, group, frame) advance in order, or are all zero on a one-second tick packet.

Once lock is declared, the block forwards the sample words with start and end markers and a per-nibble invalid mask. At the end of every forwarded packet it presents the decoded identifier and counter fields with a strobe, together with the number of invalid nibbles in that packet. Checksum and sequence faults are one-cycle pulses. The sample count per packet, the four wrap points and the lock threshold are parameters. The defaults are 128 samples and wrap points 500, 4, 24 and 20.

Top module: `lane_pkt_chk`

## Requirements
- R1: While rst_n is low at a clock edge, every output is 0 after that edge and the block is unlocked.
- R2: A packet is N_SAMP+4 words in this order: header 16'h0800, identifier word, counter word, N_SAMP sample words, checksum word. When unlocked and not tracking, any word other than 16'h0800 is discarded and produces no output.
- R3: Lock (locked=1) is declared at the checksum word of the LOCK_GOOD-th consecutive packet with a good checksum and no sequence error. A sequence error resets that run. Samples are forwarded only while locked.
- R4: Identifier word fields: bit 0 is the second tick, bits 5:4 are bank[4:3], bits 9:8 are the board, bits 12:10 are the lane and bits 15:13 are frame[2:0]. Bits 7:6 and 3:1 are ignored. Counter word fields: bits 5:0 are frame[8:3], bits 7:6 are the group, bits 12:8 are the channel and bits 15:13 are bank[2:0]. The decoded fields are valid on pkt_done.
- R5: Each sample word accepted while locked appears on smp_data with smp_valid in the cycle after it is accepted. smp_sop is set with the first sample of a packet and smp_eop with the last.
- R6: A nibble equal to 4'h8 is an invalid sample. Bit g of smp_bad flags in_data[4g+3:4g]. pkt_bad_cnt gives the number of such nibbles in the packet.
- R7: If the checksum word differs from the XOR of the packet's sample words, csum_err pulses for one cycle after it, and lock is dropped in the same cycle.
- R8: The counters advance frame first (wrapping after FRAME_MAX-1), then group (GROUP_MAX), then channel (CHAN_MAX), then bank (BANK_MAX). A packet whose tuple differs from the one expected from the previous packet raises seq_err with the packet's end. The expectation then reloads from the received tuple.
- R9: A packet with the tick bit set must carry all-zero counters. Such a packet is accepted whatever was expected. A tick packet with any non-zero counter raises seq_err.
- R10: A word other than 16'h0800 where a header is due drops lock and resumes the hunt. The first packet after the new header is not checked against the old expectation.
- R11: A cycle with in_valid low advances nothing and produces no sample, strobe or error pulse.
- R12: pkt_done pulses one cycle after the checksum word of each packet whose samples were forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | 16 | Input word from the lane |
| smp_valid | output | 1 | Forwarded sample word valid |
| smp_sop | output | 1 | First sample word of a packet |
| smp_eop | output | 1 | Last sample word of a packet |
| smp_data | output | 16 | Forwarded sample word (two complex bytes) |
| smp_bad | output | 4 | Per-nibble invalid flags |
| pkt_done | output | 1 | End-of-packet strobe for forwarded packets |
| pkt_tick | output | 1 | Second-tick flag of the packet |
| pkt_board | output | 2 | Board identifier |
| pkt_lane | output | 3 | Lane identifier |
| pkt_bank | output | 5 | Time bank counter |
| pkt_chan | output | 5 | Coarse channel counter |
| pkt_group | output | 2 | Channel group counter |
| pkt_frame | output | 9 | Frame counter |
| pkt_bad_cnt | output | clog2(4*N_SAMP+1) | Invalid nibbles in the packet |
| csum_err | output | 1 | Checksum mismatch pulse |
| seq_err | output | 1 | Counter order violation pulse |
| locked | output | 1 | Lock state |

## Verification
The hardest situation to reach is the wrap of every counter level in turn, up to the bank wrap. With the default wrap points this needs close to a million packets. The bench therefore builds the block with four samples per packet and wrap points of 3, 2, 3 and 2. It then sends packets numbered past a full counter period, deriving each tuple arithmetically from the packet number, so every carry and the return to zero occur. After that sweep, directed packets skip frames, send tick packets with zero and with non-zero counters, corrupt a checksum and omit a header. The expected lock state is tracked by a small model built from the requirements.

// File: rtl/lpc_pkg.sv
// Shared constants and types for the lane packet checker.
package lpc_pkg;
    localparam logic [15:0] LPC_HDR    = 16'h0800;  // header word, unreachable by legal samples
    localparam logic [3:0]  LPC_BADNIB = 4'h8;      // reserved nibble code, marks a bad sample
    localparam int          LPC_WORD_W = 16;
    localparam int          LPC_NIBS   = LPC_WORD_W / 4;

    // Counter tuple, slowest field first.
    typedef struct packed {
        logic [4:0] bank;
        logic [4:0] chan;
        logic [1:0] group;
        logic [8:0] frame;
    } lpc_tuple_t;

    // Identifier fields carried in the second word.
    typedef struct packed {
        logic       tick;
        logic [1:0] board;
        logic [2:0] lane;
    } lpc_id_t;
endpackage

// File: rtl/lpc_framer.sv
// Packet delineation and lock control.
// Tracks the word position inside a packet, hunts for the header when not
// tracking, and runs the lock/unlock decision. Assumes the sample and
// sequence units report their verdicts combinationally on the checksum word.
module lpc_framer
    import lpc_pkg::*;
#(
    parameter int N_SAMP    = 128,
    parameter int LOCK_GOOD = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [LPC_WORD_W-1:0] in_data,
    input  logic                  csum_bad,
    input  logic                  seq_bad,
    output logic                  ph_id,
    output logic                  ph_cnt,
    output logic                  ph_smp,
    output logic                  ph_first,
    output logic                  ph_last,
    output logic                  ph_csum,
    output logic                  hdr_miss,
    output logic                  locked_q
);
    localparam int LAST = N_SAMP + 3;
    localparam int PW   = $clog2(LAST + 1);
    localparam int GW   = $clog2(LOCK_GOOD + 1);

    logic [PW-1:0] pos_q;
    logic          sync_q;
    logic [GW-1:0] good_q;

    // Position decode, qualified by an accepted word.
    assign ph_id    = in_valid && (pos_q == PW'(1));
    assign ph_cnt   = in_valid && (pos_q == PW'(2));
    assign ph_smp   = in_valid && (pos_q >= PW'(3)) && (pos_q <= PW'(N_SAMP + 2));
    assign ph_first = in_valid && (pos_q == PW'(3));
    assign ph_last  = in_valid && (pos_q == PW'(N_SAMP + 2));
    assign ph_csum  = in_valid && (pos_q == PW'(LAST));
    assign hdr_miss = in_valid && sync_q && (pos_q == '0) && (in_data != LPC_HDR);

    // Position, tracking and lock state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q    <= '0;
            sync_q   <= 1'b0;
            locked_q <= 1'b0;
            good_q   <= '0;
        end else if (in_valid) begin
            if (pos_q == '0) begin
                if (in_data == LPC_HDR) begin
                    pos_q  <= PW'(1);
                    sync_q <= 1'b1;
                end else begin
                    sync_q   <= 1'b0;
                    locked_q <= 1'b0;
                    good_q   <= '0;
                end
            end else if (pos_q == PW'(LAST)) begin
                pos_q <= '0;
                if (csum_bad) begin
                    locked_q <= 1'b0;
                    good_q   <= '0;
                end else if (!seq_bad) begin
                    if (good_q >= GW'(LOCK_GOOD - 1)) begin
                        locked_q <= 1'b1;
                        good_q   <= GW'(LOCK_GOOD);
                    end else begin
                        good_q <= good_q + GW'(1);
                    end
                end else begin
                    good_q <= '0;
                end
            end else begin
                pos_q <= pos_q + PW'(1);
            end
        end
    end
endmodule

// File: rtl/lpc_seq.sv
// Identifier and counter decode plus counter order checking.
// Captures the fields of words two and three, derives the expected tuple of
// the next packet from the current one and flags mismatches. Tick packets
// must carry an all-zero tuple. Assumes wrap points fit the field widths.
module lpc_seq
    import lpc_pkg::*;
#(
    parameter int FRAME_MAX = 500,
    parameter int GROUP_MAX = 4,
    parameter int CHAN_MAX  = 24,
    parameter int BANK_MAX  = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LPC_WORD_W-1:0] in_data,
    input  logic                  ph_id,
    input  logic                  ph_cnt,
    input  logic                  ph_csum,
    input  logic                  hdr_miss,
    output lpc_id_t               id_q,
    output lpc_tuple_t            rx_q,
    output logic                  seq_bad,
    output logic                  seq_err_q
);
    logic [2:0] frame_lo_q;
    logic [1:0] bank_hi_q;
    lpc_tuple_t exp_q;
    logic       exp_vld_q;
    logic       unused_bits;

    assign unused_bits = ^{in_data[7:6], in_data[3:1]};

    // Successor of a tuple: frame fastest, bank slowest.
    function automatic lpc_tuple_t advance(input lpc_tuple_t t);
        lpc_tuple_t n;
        n = t;
        if (t.frame >= 9'(FRAME_MAX - 1)) begin
            n.frame = '0;
            if (t.group >= 2'(GROUP_MAX - 1)) begin
                n.group = '0;
                if (t.chan >= 5'(CHAN_MAX - 1)) begin
                    n.chan = '0;
                    if (t.bank >= 5'(BANK_MAX - 1)) n.bank = '0;
                    else                            n.bank = t.bank + 5'd1;
                end else begin
                    n.chan = t.chan + 5'd1;
                end
            end else begin
                n.group = t.group + 2'd1;
            end
        end else begin
            n.frame = t.frame + 9'd1;
        end
        return n;
    endfunction

    // Order verdict on the checksum word of the packet.
    assign seq_bad = ph_csum &&
                     (id_q.tick ? (rx_q != '0) : (exp_vld_q && (rx_q != exp_q)));

    // Field capture, expectation update and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q       <= '0;
            rx_q       <= '0;
            frame_lo_q <= '0;
            bank_hi_q  <= '0;
            exp_q      <= '0;
            exp_vld_q  <= 1'b0;
            seq_err_q  <= 1'b0;
        end else begin
            seq_err_q <= seq_bad;
            if (ph_id) begin
                id_q.tick  <= in_data[0];
                id_q.board <= in_data[9:8];
                id_q.lane  <= in_data[12:10];
                bank_hi_q  <= in_data[5:4];
                frame_lo_q <= in_data[15:13];
            end
            if (ph_cnt) begin
                rx_q.frame <= {in_data[5:0], frame_lo_q};
                rx_q.group <= in_data[7:6];
                rx_q.chan  <= in_data[12:8];
                rx_q.bank  <= {bank_hi_q, in_data[15:13]};
            end
            if (ph_csum) begin
                exp_q     <= advance(rx_q);
                exp_vld_q <= 1'b1;
            end else if (hdr_miss) begin
                exp_vld_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lpc_samp.sv
// Sample path: forwarding, invalid-nibble flagging and checksum.
// Forwards sample words while locked, marks reserved nibbles, counts them
// per packet and folds every sample word into an XOR checksum.
module lpc_samp
    import lpc_pkg::*;
#(
    parameter int N_SAMP = 128,
    parameter int CW     = $clog2(4 * N_SAMP + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LPC_WORD_W-1:0] in_data,
    input  logic                  ph_smp,
    input  logic                  ph_first,
    input  logic                  ph_last,
    input  logic                  ph_csum,
    input  logic                  locked,
    output logic                  smp_valid_q,
    output logic                  smp_sop_q,
    output logic                  smp_eop_q,
    output logic [LPC_WORD_W-1:0] smp_data_q,
    output logic [LPC_NIBS-1:0]   smp_bad_q,
    output logic [CW-1:0]         bad_cnt_q,
    output logic                  csum_bad,
    output logic                  csum_err_q
);
    logic [LPC_NIBS-1:0]   nib_bad;
    logic [2:0]            nbad;
    logic [LPC_WORD_W-1:0] acc_q;
    logic                  fwd;

    // One reserved-code detector per nibble.
    for (genvar g = 0; g < LPC_NIBS; g++) begin : g_nib
        assign nib_bad[g] = (in_data[4*g +: 4] == LPC_BADNIB);
    end

    assign nbad     = 3'($countones(nib_bad));
    assign fwd      = ph_smp && locked;
    assign csum_bad = ph_csum && (in_data != acc_q);

    // Output stage for forwarded samples and the checksum pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_valid_q <= 1'b0;
            smp_sop_q   <= 1'b0;
            smp_eop_q   <= 1'b0;
            smp_data_q  <= '0;
            smp_bad_q   <= '0;
            csum_err_q  <= 1'b0;
        end else begin
            smp_valid_q <= fwd;
            smp_sop_q   <= fwd && ph_first;
            smp_eop_q   <= fwd && ph_last;
            smp_bad_q   <= fwd ? nib_bad : '0;
            csum_err_q  <= csum_bad;
            if (fwd) smp_data_q <= in_data;
        end
    end

    // Running XOR and invalid-nibble count over the packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            bad_cnt_q <= '0;
        end else if (ph_first) begin
            acc_q     <= in_data;
            bad_cnt_q <= CW'(nbad);
        end else if (ph_smp) begin
            acc_q     <= acc_q ^ in_data;
            bad_cnt_q <= bad_cnt_q + CW'(nbad);
        end
    end
endmodule

// File: rtl/lane_pkt_chk.sv
// Lane packet checker top level.
// Wires the framer, sequence and sample units together and produces the
// packet-done strobe. Assumes one word per cycle at most, qualified by
// in_valid, with 8b/10b decoding already done upstream.
module lane_pkt_chk
    import lpc_pkg::*;
#(
    parameter int N_SAMP    = 128,
    parameter int FRAME_MAX = 500,
    parameter int GROUP_MAX = 4,
    parameter int CHAN_MAX  = 24,
    parameter int BANK_MAX  = 20,
    parameter int LOCK_GOOD = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             in_valid,
    input  logic [15:0]                      in_data,
    output logic                             smp_valid,
    output logic                             smp_sop,
    output logic                             smp_eop,
    output logic [15:0]                      smp_data,
    output logic [3:0]                       smp_bad,
    output logic                             pkt_done,
    output logic                             pkt_tick,
    output logic [1:0]                       pkt_board,
    output logic [2:0]                       pkt_lane,
    output logic [4:0]                       pkt_bank,
    output logic [4:0]                       pkt_chan,
    output logic [1:0]                       pkt_group,
    output logic [8:0]                       pkt_frame,
    output logic [$clog2(4*N_SAMP+1)-1:0]    pkt_bad_cnt,
    output logic                             csum_err,
    output logic                             seq_err,
    output logic                             locked
);
    localparam int CW = $clog2(4 * N_SAMP + 1);

    logic       ph_id, ph_cnt, ph_smp, ph_first, ph_last, ph_csum, hdr_miss;
    logic       csum_bad, seq_bad, locked_q, done_q;
    lpc_id_t    id_q;
    lpc_tuple_t rx_q;

    lpc_framer #(.N_SAMP(N_SAMP), .LOCK_GOOD(LOCK_GOOD)) u_framer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .csum_bad(csum_bad), .seq_bad(seq_bad),
        .ph_id(ph_id), .ph_cnt(ph_cnt), .ph_smp(ph_smp), .ph_first(ph_first),
        .ph_last(ph_last), .ph_csum(ph_csum), .hdr_miss(hdr_miss),
        .locked_q(locked_q)
    );

    lpc_seq #(.FRAME_MAX(FRAME_MAX), .GROUP_MAX(GROUP_MAX),
              .CHAN_MAX(CHAN_MAX), .BANK_MAX(BANK_MAX)) u_seq (
        .clk(clk), .rst_n(rst_n), .in_data(in_data),
        .ph_id(ph_id), .ph_cnt(ph_cnt), .ph_csum(ph_csum), .hdr_miss(hdr_miss),
        .id_q(id_q), .rx_q(rx_q), .seq_bad(seq_bad), .seq_err_q(seq_err)
    );

    lpc_samp #(.N_SAMP(N_SAMP), .CW(CW)) u_samp (
        .clk(clk), .rst_n(rst_n), .in_data(in_data),
        .ph_smp(ph_smp), .ph_first(ph_first), .ph_last(ph_last),
        .ph_csum(ph_csum), .locked(locked_q),
        .smp_valid_q(smp_valid), .smp_sop_q(smp_sop), .smp_eop_q(smp_eop),
        .smp_data_q(smp_data), .smp_bad_q(smp_bad), .bad_cnt_q(pkt_bad_cnt),
        .csum_bad(csum_bad), .csum_err_q(csum_err)
    );

    // Packet-done strobe for packets whose samples were forwarded.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= ph_csum && locked_q;
    end

    assign pkt_done  = done_q;
    assign locked    = locked_q;
    assign pkt_tick  = id_q.tick;
    assign pkt_board = id_q.board;
    assign pkt_lane  = id_q.lane;
    assign pkt_bank  = rx_q.bank;
    assign pkt_chan  = rx_q.chan;
    assign pkt_group = rx_q.group;
    assign pkt_frame = rx_q.frame;
endmodule

// File: rtl/lpc_chk.sv
// Temporal checks on the lane packet checker ports, bound to the top.
module lpc_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic smp_valid,
    input logic smp_sop,
    input logic smp_eop,
    input logic pkt_done,
    input logic csum_err,
    input logic seq_err,
    input logic locked
);
    // R3
    fwd_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> locked);
    // R3
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> (!csum_err && !seq_err));
    // R5
    marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_sop || smp_eop) |-> smp_valid);
    // R7
    csum_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csum_err |-> !locked);
    // R7
    csum_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csum_err |=> !csum_err);
    // R12
    done_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> $past(locked));
    // R11
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> !(smp_valid || pkt_done || csum_err || seq_err));
endmodule

bind lane_pkt_chk lpc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .smp_valid(smp_valid),
    .smp_sop(smp_sop), .smp_eop(smp_eop), .pkt_done(pkt_done),
    .csum_err(csum_err), .seq_err(seq_err), .locked(locked)
);

// File: tb/sim_lane_pkt_chk.sv
`timescale 1ns/1ps
module sim_lane_pkt_chk;
    localparam int NS = 4, FM = 3, GM = 2, CM = 3, BM = 2;
    localparam int PER = FM * GM * CM * BM;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        smp_valid, smp_sop, smp_eop, pkt_done, pkt_tick;
    logic [15:0] smp_data;
    logic [3:0]  smp_bad;
    logic [1:0]  pkt_board, pkt_group;
    logic [2:0]  pkt_lane;
    logic [4:0]  pkt_bank, pkt_chan;
    logic [8:0]  pkt_frame;
    logic [4:0]  pkt_bad_cnt;
    logic        csum_err, seq_err, locked;

    int n_chk = 0, n_fail = 0;
    bit m_locked = 0;
    int m_good = 0;

    always #4 clk = ~clk;

    lane_pkt_chk #(.N_SAMP(NS), .FRAME_MAX(FM), .GROUP_MAX(GM), .CHAN_MAX(CM),
                   .BANK_MAX(BM), .LOCK_GOOD(2)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .smp_valid(smp_valid), .smp_sop(smp_sop), .smp_eop(smp_eop),
        .smp_data(smp_data), .smp_bad(smp_bad), .pkt_done(pkt_done),
        .pkt_tick(pkt_tick), .pkt_board(pkt_board), .pkt_lane(pkt_lane),
        .pkt_bank(pkt_bank), .pkt_chan(pkt_chan), .pkt_group(pkt_group),
        .pkt_frame(pkt_frame), .pkt_bad_cnt(pkt_bad_cnt),
        .csum_err(csum_err), .seq_err(seq_err), .locked(locked)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one word at the falling edge, return 2 ns after the rising edge.
    task automatic put(input logic [15:0] w);
        @(negedge clk); in_valid = 1'b1; in_data = w;
        @(posedge clk); #2;
    endtask

    // One stalled cycle carrying the header value, which must be ignored.
    task automatic idle();
        @(negedge clk); in_valid = 1'b0; in_data = 16'h0800;
        @(posedge clk); #2;
        chk("R11 quiet while stalled", {smp_valid, pkt_done, csum_err, seq_err}, 4'b0);
    endtask

    function automatic logic [15:0] gen(input int sd, input int j);
        logic [15:0] w;
        if (sd < 0) return 16'h8888;
        w = 16'(sd * 16'h2F1B + j * 16'h0925 + 3);
        if ((sd + j) % 3 == 0) w[4*(j%4) +: 4] = 4'h8;
        return w;
    endfunction

    task automatic tup(input int i, output int bk, output int ch, output int gr, output int fr);
        fr = i % FM;
        gr = (i / FM) % GM;
        ch = (i / (FM * GM)) % CM;
        bk = (i / (FM * GM * CM)) % BM;
    endtask

    task automatic send_pkt(input int tk, input int bk, input int ch, input int gr,
                            input int fr, input int sd, input bit bad_cs,
                            input bit exp_se, input int stall_at);
        bit fwd;
        logic [15:0] w, x;
        logic [3:0] m;
        int nb;
        fwd = m_locked; x = '0; nb = 0;
        put(16'h0800);
        // R4 identifier word; bits 7:6 and 3:1 filled with junk to be ignored
        put({3'(fr), 3'd5, 2'd2, 2'b11, 2'(bk >> 3), 3'b101, 1'(tk)});
        put({3'(bk), 5'(ch), 2'(gr), 6'(fr >> 3)});
        for (int j = 0; j < NS; j++) begin
            if (j == stall_at) idle();
            w = gen(sd, j);
            for (int g = 0; g < 4; g++) m[g] = (w[4*g +: 4] == 4'h8);
            nb += $countones(m);
            x ^= w;
            put(w);
            if (fwd) begin
                chk("R5 smp_valid", smp_valid, 1);
                chk("R5 smp_data", smp_data, w);
                chk("R5 smp_sop", smp_sop, (j == 0));
                chk("R5 smp_eop", smp_eop, (j == NS - 1));
                chk("R6 smp_bad", smp_bad, m);
            end else begin
                chk("R3 no forward while unlocked", smp_valid, 0);
            end
        end
        put(bad_cs ? (x ^ 16'h0040) : x);
        chk("R12 pkt_done", pkt_done, fwd);
        chk("R7 csum_err", csum_err, bad_cs);
        chk("R8 seq_err", seq_err, exp_se);
        if (bad_cs) begin m_locked = 0; m_good = 0; end
        else if (!exp_se) begin m_good++; if (m_good >= 2) m_locked = 1; end
        else m_good = 0;
        chk("R3 locked", locked, m_locked);
        if (fwd) begin
            chk("R4 pkt_tick", pkt_tick, tk);
            chk("R4 pkt_board", pkt_board, 2);
            chk("R4 pkt_lane", pkt_lane, 5);
            chk("R4 pkt_bank", pkt_bank, bk);
            chk("R4 pkt_chan", pkt_chan, ch);
            chk("R4 pkt_group", pkt_group, gr);
            chk("R4 pkt_frame", pkt_frame, fr);
            chk("R6 pkt_bad_cnt", pkt_bad_cnt, nb);
        end
    endtask

    task automatic send_idx(input int i, input int tk, input int sd,
                            input bit bad_cs, input bit exp_se, input int st);
        int bk, ch, gr, fr;
        tup(i, bk, ch, gr, fr);
        send_pkt(tk, bk, ch, gr, fr, sd, bad_cs, exp_se, st);
    endtask

    initial begin
        #1_000_000;
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        chk("R1 outputs in reset", {smp_valid, smp_sop, smp_eop, pkt_done, csum_err,
                                    seq_err, locked, smp_bad}, '0);
        chk("R1 sample data in reset", smp_data, 0);
        @(negedge clk); rst_n = 1'b1;

        // R2 hunt: non-header words are discarded
        put(16'h1234); put(16'h0801); put(16'h8000);
        chk("R2 garbage ignored", {smp_valid, pkt_done, csum_err, seq_err, locked}, '0);
        idle();

        // R8 sweep past a full counter period with tick at each period start
        for (int i = 0; i < PER + 4; i++)
            send_idx(i, (i % PER == 0), i, 0, 0, (i % 5 == 2) ? (i % NS) : -1);

        // R8 skipped frame, then reload from the received tuple
        send_idx(PER + 5, 0, 50, 0, 1, -1);
        send_idx(PER + 6, 0, 51, 0, 0, -1);

        // R9 zero tick packet overrides expectation; non-zero tick is an error
        send_idx(0, 1, 52, 0, 0, -1);
        send_idx(1, 0, 53, 0, 0, -1);
        send_idx(5, 1, 54, 0, 1, -1);
        send_idx(6, 0, 55, 0, 0, -1);
        // R8 zero tuple without tick where non-zero is due
        send_idx(0, 0, 56, 0, 1, -1);
        send_idx(1, 0, 57, 0, 0, -1);

        // R7 checksum fault drops lock; two good packets relock
        send_idx(2, 0, 58, 1, 0, -1);
        send_idx(3, 0, 59, 0, 0, -1);
        send_idx(4, 0, 60, 0, 0, -1);
        send_idx(5, 0, 61, 0, 0, 1);

        // R4 wide field values (out of sequence), then a tick packet
        send_pkt(0, 17, 21, 1, 300, 62, 0, 1, -1);
        send_idx(0, 1, 63, 0, 0, -1);

        // R10 missing header drops lock; old expectation discarded
        put(16'h4321);
        m_locked = 0; m_good = 0;
        chk("R10 lock lost on missing header", locked, 0);
        put(16'h0000);
        send_idx(20, 0, 64, 0, 0, -1);
        send_idx(21, 0, 65, 0, 0, -1);
        send_idx(22, 0, 66, 0, 0, -1);

        // R6 packet of all reserved nibbles
        send_idx(23, 0, -1, 0, 0, -1);
        chk("R6 full invalid count", pkt_bad_cnt, 4 * NS);

        idle();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule